// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through and Read Rewind

This block is a one-way FIFO controller for 36-bit words that crosses from a write clock to an independent read clock. Data enters on the write port and leaves on the read port in order. Each side sees one status flag. What the two flags mean depends on an output mode, and the mode is latched while the hard reset is held. In standard mode the read flag signals *empty* and the write flag signals *full*. A stored word appears on `rd_data` only after a read request. In fall-through mode the read flag signals *output ready*, meaning a valid word is on `rd_data`, and the write flag signals *input ready*, meaning there is space. The oldest stored word moves onto `rd_data` with no request, and each later read request replaces it with the next word.

Besides the hard reset there is one shared control input, `flush_rt`. The `rt_mode` input decides what it does. With `rt_mode` low, `flush_rt` flushes the FIFO: both pointers go back to the first location and the latched mode is kept. With `rt_mode` high, it rewinds only the read pointer, so the stored words can be read again from the first one onward. The write pointer does not move.

The write pointer and read pointer cross between the clock domains as Gray code through synchronizer chains of `SYNC_N` stages. Each flag is registered in its own clock domain. The read side is built around a two-state machine. `RD_NOWORD` means no word is held on the output. `RD_SHOWN` means a fall-through word is held. The read-side transitions are:
- *fetch*: `RD_NOWORD` → `RD_SHOWN`, in fall-through mode only, when memory holds data.
- *advance*: `RD_SHOWN` → `RD_SHOWN`, on a read while more data is stored; the next word is loaded.
- *drain*: `RD_SHOWN` → `RD_NOWORD`, on a read while memory is empty.
- *drop*: `RD_SHOWN` → `RD_NOWORD`, on a reset, flush or rewind.

The write side has two states. `WS_OPEN` moves to `WS_FULL` when the next occupancy equals the depth, and moves back once the synchronized read pointer frees a slot. Every control input is synchronous and must be held for at least `SYNC_N`+2 cycles of each clock, except the rewind, which takes one read clock cycle.

Top module: `dmf_fifo`

## Requirements
- R1: While `hard_rst` is held, the block returns to its empty state. After release, `rd_data` is 0. In standard mode `rflag`=1 (empty) and `wflag`=0 (not full). In fall-through mode `rflag`=0 (no output ready) and `wflag`=1 (input ready).
- R2: `fwft_sel` is sampled only while `hard_rst` is high: 1 selects fall-through and 0 selects standard. Changes at any other time have no effect on the flags or on the data path.
- R3: In standard mode a stored word leaves memory only on a read clock edge where `rd_en`=1 and `rflag`=0. That word appears on `rd_data` after that edge, and words come out in write order. `rd_data` holds its value when `rd_en` is low.
- R4: In fall-through mode the oldest stored word appears on `rd_data` with `rflag`=1 and no read request. It stays there until an edge with `rd_en`=1, which loads the next word. If no word is stored, that edge drops `rflag` to 0.
- R5: Once DEPTH (`2**AW`) words are held in memory, the write flag reports no space: `wflag`=1 in standard mode, `wflag`=0 in fall-through mode. In fall-through mode the word on the output is not counted in memory.
- R6: A write while the FIFO is full is ignored. The write pointer does not move, and no stored word is overwritten.
- R7: A read request while memory is empty (standard mode) or while no word is shown (fall-through mode) is ignored. `rd_data` and the read pointer are unchanged.
- R8: `flush_rt`=1 with `rt_mode`=0 empties the FIFO. Both pointers return to the first location and the flags return to the R1 values for the mode latched at the last hard reset, even if `fwft_sel` has changed since.
- R9: `flush_rt`=1 with `rt_mode`=1 returns only the read pointer to the first location. Reading then restarts at the first word written since the last reset. Later writes are appended after the words already stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| hard_rst | input | 1 | Hard reset, active high; latches `fwft_sel` |
| fwft_sel | input | 1 | Mode select sampled during hard reset: 1 fall-through, 0 standard |
| flush_rt | input | 1 | Shared flush / rewind request, active high |
| rt_mode | input | 1 | Meaning of `flush_rt`: 0 flush, 1 read rewind |
| wr_en | input | 1 | Write request (write clock) |
| wr_data | input | DW | Write word |
| wflag | output | 1 | Full (standard) or input ready (fall-through) |
| rd_en | input | 1 | Read request (read clock) |
| rd_data | output | DW | Read word register |
| rflag | output | 1 | Empty (standard) or output ready (fall-through) |

## Verification
The assertions check the following on every clock edge:
- Neither pointer moves while its side reports full or empty.
- Occupancy, measured against the synchronized read pointer, never exceeds the depth.
- The latched mode holds between hard resets.
- A flush clears the write side, and a rewind clears the read pointer.
- In standard mode `rd_data` holds without a request, and in fall-through mode a shown word holds without a request.

The bench scenarios are needed for the rest:
- the values that come out and their order;
- that a write into a full FIFO destroys nothing;
- that a rewind replays the first words and that later writes append after them;
- that a flush keeps the latched mode when `fwft_sel` has changed.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

    // Read-side output holding state
    typedef enum logic {
        RD_NOWORD = 1'b0,
        RD_SHOWN  = 1'b1
    } rd_state_e;

    // Write-side space state
    typedef enum logic {
        WS_OPEN = 1'b0,
        WS_FULL = 1'b1
    } wr_state_e;

endpackage

// File: rtl/dmf_sync.sv
module dmf_sync #(
    parameter int W = 5,
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] st_q [N];

    always_ff @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < N; i++) st_q[i] <= '0;
        end else begin
            st_q[0] <= d;
            for (int i = 1; i < N; i++) st_q[i] <= st_q[i-1];
        end
    end

    assign q = st_q[N-1];

endmodule

// File: rtl/dmf_g2b.sv
module dmf_g2b #(
    parameter int W = 5
) (
    input  logic [W-1:0] g,
    output logic [W-1:0] b
);

    for (genvar k = 0; k < W; k++) begin : g_bit
        assign b[k] = ^(g >> k);
    end

endmodule

// File: rtl/dmf_wr_ctrl.sv
module dmf_wr_ctrl
    import dmf_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          hard_rst,
    input  logic          flush,
    input  logic          fwft_sel,
    input  logic          wr_en,
    input  logic [AW:0]   rgray_sync,
    output logic          push,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          wflag,
    output logic [AW:0]   wbin,
    output logic [AW:0]   rbin_sync,
    output logic          is_full
);

    localparam logic [AW:0] FULL_OCC = {1'b1, {AW{1'b0}}};

    wr_state_e   st_q, st_nx;
    logic [AW:0] wbin_q, wbin_nx;
    logic        mode_q;

    dmf_g2b #(.W(AW+1)) i_g2b (
        .g (rgray_sync),
        .b (rbin_sync)
    );

    always_ff @(posedge clk) begin
        if (hard_rst) mode_q <= fwft_sel;
    end

    assign push    = wr_en && (st_q == WS_OPEN);
    assign wbin_nx = wbin_q + (AW+1)'(push);

    always_comb begin
        st_nx = ((wbin_nx - rbin_sync) == FULL_OCC) ? WS_FULL : WS_OPEN;
    end

    always_ff @(posedge clk) begin
        if (hard_rst || flush) begin
            st_q   <= WS_OPEN;
            wbin_q <= '0;
            wgray  <= '0;
        end else begin
            st_q   <= st_nx;
            wbin_q <= wbin_nx;
            wgray  <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    always_comb begin
        unique case (st_q)
            WS_OPEN: is_full = 1'b0;
            WS_FULL: is_full = 1'b1;
        endcase
        wflag = mode_q ? !is_full : is_full;
    end

    assign waddr = wbin_q[AW-1:0];
    assign wbin  = wbin_q;

endmodule

// File: rtl/dmf_rd_ctrl.sv
module dmf_rd_ctrl
    import dmf_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          hard_rst,
    input  logic          flush,
    input  logic          rewind,
    input  logic          fwft_sel,
    input  logic          rd_en,
    input  logic [AW:0]   wgray_sync,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] rd_data,
    output logic          rflag,
    output logic [AW:0]   rbin,
    output logic          mem_empty,
    output logic          mode
);

    rd_state_e   st_q, st_nx;
    logic [AW:0] rbin_q, rbin_nx, wbin_sync;
    logic        empty_q, empty_nx;
    logic        mode_q;
    logic        pop;

    dmf_g2b #(.W(AW+1)) i_g2b (
        .g (wgray_sync),
        .b (wbin_sync)
    );

    always_ff @(posedge clk) begin
        if (hard_rst) mode_q <= fwft_sel;
    end

    // Next state and fetch decision
    always_comb begin
        st_nx = st_q;
        pop   = 1'b0;
        unique case (st_q)
            RD_NOWORD: begin
                if (!empty_q && (mode_q || rd_en)) begin
                    pop   = 1'b1;
                    st_nx = mode_q ? RD_SHOWN : RD_NOWORD;
                end
            end
            RD_SHOWN: begin
                if (rd_en) begin
                    if (!empty_q) pop   = 1'b1;
                    else          st_nx = RD_NOWORD;
                end
            end
        endcase
    end

    assign rbin_nx  = rbin_q + (AW+1)'(pop);
    assign empty_nx = (rbin_nx == wbin_sync);

    // State register and pointers
    always_ff @(posedge clk) begin
        if (hard_rst || flush || rewind) begin
            st_q    <= RD_NOWORD;
            rbin_q  <= '0;
            rgray   <= '0;
            empty_q <= 1'b1;
        end else begin
            st_q    <= st_nx;
            rbin_q  <= rbin_nx;
            rgray   <= rbin_nx ^ (rbin_nx >> 1);
            empty_q <= empty_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (hard_rst)  rd_data <= '0;
        else if (pop)  rd_data <= mem_rdata;
    end

    // Outputs
    always_comb begin
        unique case (st_q)
            RD_NOWORD: rflag = mode_q ? 1'b0 : empty_q;
            RD_SHOWN:  rflag = 1'b1;
        endcase
    end

    assign raddr     = rbin_q[AW-1:0];
    assign rbin      = rbin_q;
    assign mem_empty = empty_q;
    assign mode      = mode_q;

endmodule

// File: rtl/dmf_fifo.sv
module dmf_fifo #(
    parameter int DW     = 36,
    parameter int AW     = 4,
    parameter int SYNC_N = 2
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          hard_rst,
    input  logic          fwft_sel,
    input  logic          flush_rt,
    input  logic          rt_mode,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          wflag,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rflag
);

    localparam int DEPTH = 1 << AW;

    logic          flush_req, rewind_req;
    logic          push;
    logic [AW-1:0] waddr, raddr;
    logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
    logic [AW:0]   w_bin, w_rsync_bin, r_bin;
    logic          w_full, r_empty, r_mode;
    logic [DW-1:0] mem_q [DEPTH];

    assign flush_req  = flush_rt && !rt_mode;
    assign rewind_req = flush_rt && rt_mode;

    always_ff @(posedge wr_clk) begin
        if (push) mem_q[waddr] <= wr_data;
    end

    dmf_sync #(.W(AW+1), .N(SYNC_N)) i_sync_r2w (
        .clk (wr_clk),
        .clr (hard_rst || flush_req),
        .d   (rgray),
        .q   (rgray_s)
    );

    dmf_sync #(.W(AW+1), .N(SYNC_N)) i_sync_w2r (
        .clk (rd_clk),
        .clr (hard_rst || flush_req),
        .d   (wgray),
        .q   (wgray_s)
    );

    dmf_wr_ctrl #(.AW(AW)) i_wr (
        .clk        (wr_clk),
        .hard_rst   (hard_rst),
        .flush      (flush_req),
        .fwft_sel   (fwft_sel),
        .wr_en      (wr_en),
        .rgray_sync (rgray_s),
        .push       (push),
        .waddr      (waddr),
        .wgray      (wgray),
        .wflag      (wflag),
        .wbin       (w_bin),
        .rbin_sync  (w_rsync_bin),
        .is_full    (w_full)
    );

    dmf_rd_ctrl #(.AW(AW), .DW(DW)) i_rd (
        .clk        (rd_clk),
        .hard_rst   (hard_rst),
        .flush      (flush_req),
        .rewind     (rewind_req),
        .fwft_sel   (fwft_sel),
        .rd_en      (rd_en),
        .wgray_sync (wgray_s),
        .mem_rdata  (mem_q[raddr]),
        .raddr      (raddr),
        .rgray      (rgray),
        .rd_data    (rd_data),
        .rflag      (rflag),
        .rbin       (r_bin),
        .mem_empty  (r_empty),
        .mode       (r_mode)
    );

endmodule

// File: rtl/dmf_fifo_chk.sv
module dmf_fifo_chk #(
    parameter int AW = 4,
    parameter int DW = 36
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          hard_rst,
    input logic          flush_rt,
    input logic          rt_mode,
    input logic          rd_en,
    input logic [DW-1:0] rd_data,
    input logic          rflag,
    input logic [AW:0]   w_bin,
    input logic [AW:0]   w_rsync_bin,
    input logic          w_full,
    input logic [AW:0]   r_bin,
    input logic          r_empty,
    input logic          r_mode
);

    localparam logic [AW:0] FULL_OCC = {1'b1, {AW{1'b0}}};

    // R2: latched mode holds between hard resets
    a_r2_mode_held: assert property (@(posedge rd_clk) disable iff (hard_rst)
        1'b1 |=> $stable(r_mode));

    // R3: standard mode output holds without a request
    a_r3_std_hold: assert property (@(posedge rd_clk) disable iff (hard_rst || flush_rt)
        (!r_mode && !rd_en) |=> $stable(rd_data));

    // R4: a shown fall-through word holds until requested
    a_r4_fwft_hold: assert property (@(posedge rd_clk) disable iff (hard_rst || flush_rt)
        (r_mode && rflag && !rd_en) |=> (rflag && $stable(rd_data)));

    // R5: occupancy seen from the write side never exceeds depth
    a_r5_occupancy: assert property (@(posedge wr_clk) disable iff (hard_rst || flush_rt)
        (w_bin - w_rsync_bin) <= FULL_OCC);

    // R6: no write pointer movement while full
    a_r6_no_overflow: assert property (@(posedge wr_clk) disable iff (hard_rst || flush_rt)
        w_full |=> $stable(w_bin));

    // R7: no read pointer movement while memory empty
    a_r7_no_underflow: assert property (@(posedge rd_clk) disable iff (hard_rst || flush_rt)
        r_empty |=> $stable(r_bin));

    // R8: flush clears the write side
    a_r8_flush_clears: assert property (@(posedge wr_clk) disable iff (hard_rst)
        (flush_rt && !rt_mode) |=> (w_bin == '0 && !w_full));

    // R9: rewind returns the read pointer to the first location
    a_r9_rewind_rptr: assert property (@(posedge rd_clk) disable iff (hard_rst)
        (flush_rt && rt_mode) |=> (r_bin == '0));

endmodule

bind dmf_fifo dmf_fifo_chk #(.AW(AW), .DW(DW)) i_chk (
    .wr_clk      (wr_clk),
    .rd_clk      (rd_clk),
    .hard_rst    (hard_rst),
    .flush_rt    (flush_rt),
    .rt_mode     (rt_mode),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .rflag       (rflag),
    .w_bin       (w_bin),
    .w_rsync_bin (w_rsync_bin),
    .w_full      (w_full),
    .r_bin       (r_bin),
    .r_empty     (r_empty),
    .r_mode      (r_mode)
);

// File: tb/test_dmf_fifo.sv
module test_dmf_fifo;

    localparam int DW    = 36;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    // Vector table, standard mode: write or read, data written / expected, rflag after
    localparam int NV = 8;
    localparam bit VEC_RD [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
    localparam logic [DW-1:0] VEC_VAL [NV] = '{
        36'h0_A1A1_0001, 36'h0_B2B2_0002, 36'h0_C3C3_0003, 36'h0_A1A1_0001,
        36'h0_B2B2_0002, 36'hF_D4D4_0004, 36'h0_C3C3_0003, 36'hF_D4D4_0004};
    localparam bit VEC_EF [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          hard_rst = 1'b1;
    logic          fwft_sel = 1'b0;
    logic          flush_rt = 1'b0;
    logic          rt_mode = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wflag;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rflag;

    int n_chk = 0;
    int n_bad = 0;

    always #5ns wr_clk = ~wr_clk;
    always #7ns rd_clk = ~rd_clk;

    dmf_fifo #(.DW(DW), .AW(AW), .SYNC_N(2)) i_dmf_fifo (
        .wr_clk   (wr_clk),
        .rd_clk   (rd_clk),
        .hard_rst (hard_rst),
        .fwft_sel (fwft_sel),
        .flush_rt (flush_rt),
        .rt_mode  (rt_mode),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wflag    (wflag),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rflag    (rflag)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge rd_clk);
    endtask

    task automatic do_hard_reset(input logic m);
        @(negedge rd_clk);
        fwft_sel = m;
        hard_rst = 1'b1;
        repeat (5) @(negedge rd_clk);
        hard_rst = 1'b0;
        settle();
    endtask

    task automatic do_write(input logic [DW-1:0] v);
        @(negedge wr_clk);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge wr_clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_read();
        @(negedge rd_clk);
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge rd_clk);
        rt_mode  = 1'b0;
        flush_rt = 1'b1;
        repeat (5) @(negedge rd_clk);
        flush_rt = 1'b0;
        settle();
    endtask

    task automatic do_rewind();
        @(negedge rd_clk);
        rt_mode = 1'b1;
        @(negedge rd_clk);
        flush_rt = 1'b1;
        @(negedge rd_clk);
        flush_rt = 1'b0;
        @(negedge rd_clk);
        rt_mode = 1'b0;
        settle();
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return DW'(36'h5_0000_0000 + (i * 36'h0_0101_0011));
    endfunction

    initial begin
        #400us;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        // ---------------- standard mode reset state (R1)
        do_hard_reset(1'b0);
        check("R1 std rflag empty", 64'(rflag), 64'd1);
        check("R1 std wflag not full", 64'(wflag), 64'd0);
        check("R1 rd_data cleared", 64'(rd_data), 64'd0);

        // ---------------- vector table walk (R3)
        for (int v = 0; v < NV; v++) begin
            if (VEC_RD[v]) begin
                do_read();
                check("R3 read order", 64'(rd_data), 64'(VEC_VAL[v]));
            end else begin
                do_write(VEC_VAL[v]);
                settle();
            end
            check("R3 empty flag", 64'(rflag), 64'(VEC_EF[v]));
        end

        // ---------------- read while empty (R7)
        do_read();
        check("R7 data kept on empty read", 64'(rd_data), 64'(VEC_VAL[NV-1]));
        do_write(36'h7_7777_0007);
        settle();
        do_read();
        check("R7 pointer unmoved", 64'(rd_data), 64'h7_7777_0007);

        // ---------------- mode change outside reset, then fill (R2, R5, R6)
        do_hard_reset(1'b0);
        fwft_sel = 1'b1;
        settle();
        check("R2 rflag keeps standard meaning", 64'(rflag), 64'd1);
        check("R2 wflag keeps standard meaning", 64'(wflag), 64'd0);
        for (int i = 0; i < DEPTH; i++) do_write(pat(i));
        settle();
        check("R5 std full flag", 64'(wflag), 64'd1);
        check("R2 no fall-through on change", 64'(rd_data), 64'd0);
        do_write(36'hB_ADBA_D000);
        settle();
        for (int i = 0; i < DEPTH; i++) begin
            do_read();
            check("R6 stored word intact", 64'(rd_data), 64'(pat(i)));
        end
        check("R6 extra write dropped", 64'(rflag), 64'd1);
        settle();
        check("R5 full released", 64'(wflag), 64'd0);
        fwft_sel = 1'b0;

        // ---------------- standard rewind (R9)
        do_hard_reset(1'b0);
        for (int i = 0; i < 3; i++) do_write(pat(20 + i));
        settle();
        do_read();
        do_read();
        check("R9 second word before rewind", 64'(rd_data), 64'(pat(21)));
        do_rewind();
        check("R9 not empty after rewind", 64'(rflag), 64'd0);
        do_read();
        check("R9 replay first word", 64'(rd_data), 64'(pat(20)));
        do_write(pat(23));
        settle();
        for (int i = 1; i < 4; i++) begin
            do_read();
            check("R9 write pointer kept", 64'(rd_data), 64'(pat(20 + i)));
        end
        check("R9 empty after replay", 64'(rflag), 64'd1);

        // ---------------- flush keeps mode (R8)
        do_write(pat(30));
        do_write(pat(31));
        settle();
        fwft_sel = 1'b1;
        do_flush();
        check("R8 flush empties (std)", 64'(rflag), 64'd1);
        check("R8 flush wflag (std)", 64'(wflag), 64'd0);
        do_write(pat(32));
        settle();
        do_read();
        check("R8 read after flush", 64'(rd_data), 64'(pat(32)));

        // ---------------- fall-through reset and basic (R1, R4, R7)
        do_hard_reset(1'b1);
        fwft_sel = 1'b0;
        check("R1 fwft rflag not ready", 64'(rflag), 64'd0);
        check("R1 fwft wflag ready", 64'(wflag), 64'd1);
        check("R1 fwft rd_data cleared", 64'(rd_data), 64'd0);
        do_write(pat(40));
        settle();
        check("R4 word falls through", 64'(rd_data), 64'(pat(40)));
        check("R4 output ready", 64'(rflag), 64'd1);
        do_write(pat(41));
        settle();
        check("R4 shown word held", 64'(rd_data), 64'(pat(40)));
        do_read();
        check("R4 read loads next", 64'(rd_data), 64'(pat(41)));
        check("R4 still ready", 64'(rflag), 64'd1);
        do_read();
        check("R4 not ready when drained", 64'(rflag), 64'd0);
        do_read();
        check("R7 no change when not ready", 64'(rd_data), 64'(pat(41)));
        check("R7 flag stays low", 64'(rflag), 64'd0);

        // ---------------- fall-through fill (R5, R6)
        do_hard_reset(1'b1);
        for (int i = 0; i < DEPTH; i++) do_write(pat(50 + i));
        settle();
        check("R5 space with word on output", 64'(wflag), 64'd1);
        do_write(pat(50 + DEPTH));
        settle();
        check("R5 fwft input not ready", 64'(wflag), 64'd0);
        do_write(36'hB_ADBA_D001);
        settle();
        check("R6 first shown word", 64'(rd_data), 64'(pat(50)));
        for (int i = 1; i <= DEPTH; i++) begin
            do_read();
            check("R6 fwft stored word intact", 64'(rd_data), 64'(pat(50 + i)));
        end
        do_read();
        check("R6 fwft extra write dropped", 64'(rflag), 64'd0);
        settle();
        check("R5 fwft space again", 64'(wflag), 64'd1);

        // ---------------- fall-through rewind and flush (R9, R8)
        do_hard_reset(1'b1);
        for (int i = 0; i < 3; i++) do_write(pat(80 + i));
        settle();
        do_read();
        check("R9 fwft before rewind", 64'(rd_data), 64'(pat(81)));
        do_rewind();
        check("R9 fwft replay first word", 64'(rd_data), 64'(pat(80)));
        check("R9 fwft ready after rewind", 64'(rflag), 64'd1);
        do_read();
        check("R9 fwft replay order", 64'(rd_data), 64'(pat(81)));
        do_flush();
        check("R8 fwft flush not ready", 64'(rflag), 64'd0);
        check("R8 fwft flush input ready", 64'(wflag), 64'd1);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule